// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is the target side of a two-wire serial bus used to program and inspect a byte-addressed bank of configuration registers. It watches the clock and data lines through a system-clock oversampler, recognises bus start and stop events, and checks the first byte of a frame against its 7-bit device address. A write frame loads an 8-bit register pointer and then stores data bytes one after another. A read frame returns bytes starting at the pointer. The pointer advances by one after every byte that is stored or returned.

The register storage sits outside the block. The slave drives a one-cycle write strobe with an address and data, and it presents a read address to a combinational read port. Only two address windows hold real registers. The slave blocks write strobes to any other address, and it returns zero when such an address is read. The data line is open-drain. The block only ever pulls it low, through an output-enable pin.

Top module: `cfg_2w_slave`

## Requirements
- R1: A start (data falling while clock is high) enters device-address matching from any state, and a stop (data rising while clock is high) returns the slave to idle. In both cases the data line is released on the next cycle.
- R2: The first byte after a start is the 7-bit device address (default 69H) followed by the direction bit in the LSB (0 = write, 1 = read). A matching address is acknowledged by pulling data low during the 9th clock. The slave's data drive changes only while the clock is low.
- R3: A device address that does not match leaves the data line released, including in every acknowledge slot, until the next start. It produces no write strobe.
- R4: In a write frame the byte after the device address loads the register pointer. Every later byte is acknowledged and is committed as a single-cycle write strobe at that byte's acknowledge.
- R5: After each stored or returned byte the pointer advances by one, and it wraps from FFH to 00H.
- R6: A data byte aimed at an address outside 08H–1BH and 40H–57H is acknowledged but produces no write strobe.
- R7: A read of an address outside 08H–1BH and 40H–57H returns 00H, whatever the read port presents.
- R8: A read frame that does not set a new pointer returns location n+1, where n is the last location written or read.
- R9: A write frame that sets the pointer and is followed by a repeated start and a read-direction address returns the byte at that pointer.
- R10: In a read, a master acknowledge makes the slave send the next byte. A master no-acknowledge ends the transfer, and the slave then leaves data released.
- R11: A repeated start in the middle of a byte discards that partial byte and returns the slave to address matching.
- R12: A clock pulse shorter than the glitch filter length is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_o | output | 1 | Value driven on the data line when enabled (always 0) |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| rf_we_o | output | 1 | Register write strobe, one cycle per committed byte |
| rf_waddr_o | output | 8 | Register write address |
| rf_wdata_o | output | 8 | Register write data |
| rf_raddr_o | output | 8 | Register read address (current pointer) |
| rf_rdata_i | input | 8 | Register read data, combinational from rf_raddr_o |

## Verification
The assertions assume a well-behaved bus master. It moves the data line only while the clock is low, except when it deliberately signals a start or a stop. It also spaces every line change further apart than the synchronizer and filter latency, so both filtered lines keep their true order. The stimulus keeps to this by building each bit from four equal phases of 20 system clocks and changing data only in the middle of a low phase. The one deliberate violation is a 2-cycle clock spike. It is shorter than the filter length, so the filtered clock never shows it to the protocol logic.

// File: rtl/cfg2w_pkg.sv
package cfg2w_pkg;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_DEV,
        PH_DEV_ACK,
        PH_REG,
        PH_REG_ACK,
        PH_WR,
        PH_WR_ACK,
        PH_RD,
        PH_RD_MACK
    } phase_e;

    localparam logic [7:0] WIN0_LO = 8'h08;
    localparam logic [7:0] WIN0_HI = 8'h1B;
    localparam logic [7:0] WIN1_LO = 8'h40;
    localparam logic [7:0] WIN1_HI = 8'h57;

    // True when a real register lives at this address.
    function automatic logic reg_present(input logic [7:0] a);
        return ((a >= WIN0_LO) && (a <= WIN0_HI)) ||
               ((a >= WIN1_LO) && (a <= WIN1_HI));
    endfunction

endpackage

// File: rtl/cfg2w_filter.sv
// Synchronizer followed by a persistence filter: the output follows the
// synchronized input only after it has differed for FILT_LEN samples.
module cfg2w_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic clean_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [CW-1:0]          cnt;
        logic                   out;
    } flt_t;

    flt_t q, d;

    always_comb begin
        d      = q;
        d.sync = {q.sync[SYNC_STAGES-2:0], raw_i};
        if (q.sync[SYNC_STAGES-1] != q.out) begin
            if (q.cnt == CW'(FILT_LEN - 1)) begin
                d.out = q.sync[SYNC_STAGES-1];
                d.cnt = '0;
            end else begin
                d.cnt = q.cnt + CW'(1);
            end
        end else begin
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sync <= '1;
            q.cnt  <= '0;
            q.out  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign clean_o = q.out;

endmodule

// File: rtl/cfg2w_cond.sv
// Bus event detector on the filtered lines.
module cfg2w_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic scl_hi_o,
    output logic start_o,
    output logic stop_o
);
    typedef struct packed {
        logic scl;
        logic sda;
    } prev_t;

    prev_t q, d;

    always_comb begin
        d.scl = scl_i;
        d.sda = sda_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '1;
        end else begin
            q <= d;
        end
    end

    assign scl_rise_o = scl_i & ~q.scl;
    assign scl_fall_o = ~scl_i & q.scl;
    assign scl_hi_o   = scl_i & q.scl;
    assign start_o    = scl_i & q.scl & q.sda & ~sda_i;
    assign stop_o     = scl_i & q.scl & ~q.sda & sda_i;

endmodule

// File: rtl/cfg2w_engine.sv
// Protocol engine: address match, pointer, write strobes, read shifter.
module cfg2w_engine
    import cfg2w_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_rise_i,
    input  logic       scl_fall_i,
    input  logic       scl_hi_i,
    input  logic       sda_i,
    input  logic       start_i,
    input  logic       stop_i,
    output logic       sda_oe_o,
    output logic       rf_we_o,
    output logic [7:0] rf_waddr_o,
    output logic [7:0] rf_wdata_o,
    output logic [7:0] rf_raddr_o,
    input  logic [7:0] rf_rdata_i
);
    typedef struct packed {
        phase_e     phase;
        logic [3:0] bitcnt;
        logic [7:0] sh;
        logic [7:0] ptr;
        logic       rw;
        logic       mack;
        logic       oe;
        logic       we;
        logic [7:0] waddr;
        logic [7:0] wdata;
    } eng_t;

    eng_t q, d;
    logic [7:0] rd_byte;

    assign rd_byte = reg_present(q.ptr) ? rf_rdata_i : 8'h00;

    always_comb begin
        d    = q;
        d.we = 1'b0;
        if (start_i) begin
            d.phase  = PH_DEV;
            d.bitcnt = '0;
            d.oe     = 1'b0;
        end else if (stop_i) begin
            d.phase = PH_IDLE;
            d.oe    = 1'b0;
        end else begin
            unique case (q.phase)
                PH_DEV, PH_REG, PH_WR: begin
                    if (scl_rise_i) begin
                        d.sh     = {q.sh[6:0], sda_i};
                        d.bitcnt = q.bitcnt + 4'd1;
                    end
                    if (scl_fall_i && q.bitcnt == 4'd8) begin
                        if (q.phase == PH_DEV) begin
                            if (q.sh[7:1] == DEV_ADDR) begin
                                d.rw    = q.sh[0];
                                d.oe    = 1'b1;
                                d.phase = PH_DEV_ACK;
                            end else begin
                                d.phase = PH_IDLE;
                            end
                        end else if (q.phase == PH_REG) begin
                            d.ptr   = q.sh;
                            d.oe    = 1'b1;
                            d.phase = PH_REG_ACK;
                        end else begin
                            d.we    = reg_present(q.ptr);
                            d.waddr = q.ptr;
                            d.wdata = q.sh;
                            d.ptr   = q.ptr + 8'd1;
                            d.oe    = 1'b1;
                            d.phase = PH_WR_ACK;
                        end
                    end
                end
                PH_DEV_ACK: begin
                    if (scl_fall_i) begin
                        d.bitcnt = '0;
                        if (q.rw) begin
                            d.sh    = rd_byte;
                            d.oe    = ~rd_byte[7];
                            d.ptr   = q.ptr + 8'd1;
                            d.phase = PH_RD;
                        end else begin
                            d.oe    = 1'b0;
                            d.phase = PH_REG;
                        end
                    end
                end
                PH_REG_ACK, PH_WR_ACK: begin
                    if (scl_fall_i) begin
                        d.oe     = 1'b0;
                        d.bitcnt = '0;
                        d.phase  = PH_WR;
                    end
                end
                PH_RD: begin
                    if (scl_rise_i) begin
                        d.bitcnt = q.bitcnt + 4'd1;
                    end
                    if (scl_fall_i) begin
                        if (q.bitcnt == 4'd8) begin
                            d.oe    = 1'b0;
                            d.phase = PH_RD_MACK;
                        end else begin
                            d.sh = {q.sh[6:0], 1'b0};
                            d.oe = ~q.sh[6];
                        end
                    end
                end
                PH_RD_MACK: begin
                    if (scl_rise_i) begin
                        d.mack = ~sda_i;
                    end
                    if (scl_fall_i) begin
                        if (q.mack) begin
                            d.bitcnt = '0;
                            d.sh     = rd_byte;
                            d.oe     = ~rd_byte[7];
                            d.ptr    = q.ptr + 8'd1;
                            d.phase  = PH_RD;
                        end else begin
                            d.phase = PH_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.phase <= PH_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o   = q.oe;
    assign rf_we_o    = q.we;
    assign rf_waddr_o = q.waddr;
    assign rf_wdata_o = q.wdata;
    assign rf_raddr_o = q.ptr;

    // R1: a start releases the line and begins address matching
    assert_start_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (!sda_oe_o && q.phase == PH_DEV));

    // R1: a stop releases the line and idles the engine
    assert_stop_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (!sda_oe_o && q.phase == PH_IDLE));

    // R2: drive is steady while the clock stays high
    assert_drive_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_hi_i && !start_i && !stop_i) |=> $stable(sda_oe_o));

    // R4: each committed byte is a single-cycle strobe
    assert_we_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we_o |=> !rf_we_o);

    // R6: strobes only reach implemented registers
    assert_we_in_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we_o |-> reg_present(rf_waddr_o));

endmodule

// File: rtl/cfg_2w_slave.sv
module cfg_2w_slave #(
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter int         SYNC_STAGES = 2,
    parameter int         FILT_LEN    = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_o,
    output logic       sda_oe_o,
    output logic       rf_we_o,
    output logic [7:0] rf_waddr_o,
    output logic [7:0] rf_wdata_o,
    output logic [7:0] rf_raddr_o,
    input  logic [7:0] rf_rdata_i
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw_lines;
    logic [NLINES-1:0] clean_lines;
    logic scl_rise, scl_fall, scl_hi, start_ev, stop_ev;

    assign raw_lines = {scl_i, sda_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        cfg2w_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
        ) u_flt (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (raw_lines[g]),
            .clean_o(clean_lines[g])
        );
    end

    cfg2w_cond u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (clean_lines[1]),
        .sda_i     (clean_lines[0]),
        .scl_rise_o(scl_rise),
        .scl_fall_o(scl_fall),
        .scl_hi_o  (scl_hi),
        .start_o   (start_ev),
        .stop_o    (stop_ev)
    );

    cfg2w_engine #(
        .DEV_ADDR(DEV_ADDR)
    ) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise_i(scl_rise),
        .scl_fall_i(scl_fall),
        .scl_hi_i  (scl_hi),
        .sda_i     (clean_lines[0]),
        .start_i   (start_ev),
        .stop_i    (stop_ev),
        .sda_oe_o  (sda_oe_o),
        .rf_we_o   (rf_we_o),
        .rf_waddr_o(rf_waddr_o),
        .rf_wdata_o(rf_wdata_o),
        .rf_raddr_o(rf_raddr_o),
        .rf_rdata_i(rf_rdata_i)
    );

    assign sda_o = 1'b0;

endmodule

// File: tb/sim_cfg_2w_slave.sv
`timescale 1ns/1ps
module sim_cfg_2w_slave;

    localparam int Q = 20;
    localparam logic [7:0] DW = 8'hD2;
    localparam logic [7:0] DR = 8'hD3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic glitch = 1'b0;
    logic sda_line, sda_o, sda_oe;
    logic rf_we;
    logic [7:0] rf_waddr, rf_wdata, rf_raddr, rf_rdata;

    logic [7:0] regs [256];
    logic [15:0] exp_wr [$];

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;
    assign rf_rdata = regs[rf_raddr];

    cfg_2w_slave u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_m | glitch),
        .sda_i     (sda_line),
        .sda_o     (sda_o),
        .sda_oe_o  (sda_oe),
        .rf_we_o   (rf_we),
        .rf_waddr_o(rf_waddr),
        .rf_wdata_o(rf_wdata),
        .rf_raddr_o(rf_raddr),
        .rf_rdata_i(rf_rdata)
    );

    function automatic bit in_win(input logic [7:0] a);
        return (a >= 8'h08 && a <= 8'h1B) || (a >= 8'h40 && a <= 8'h57);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // external register storage
    always @(posedge clk) if (rf_we) regs[rf_waddr] <= rf_wdata;

    // per-clock comparison of write strobes against the model queue
    always @(negedge clk) begin
        if (rst_n && rf_we) begin
            if (exp_wr.size() == 0) begin
                check(0, "R6 unexpected write strobe", {rf_waddr, rf_wdata}, 0);
            end else begin
                check({rf_waddr, rf_wdata} == exp_wr[0], "R4 write strobe",
                      {rf_waddr, rf_wdata}, exp_wr[0]);
                void'(exp_wr.pop_front());
            end
        end
    end

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bit_cycle(input logic b, output logic s);
        sda_m = b;  wait_q();
        scl_m = 1'b1; wait_q();
        s = sda_line; wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic do_start();
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic do_stop(input string tag);
        sda_m = 1'b0; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b1; wait_q();
        wait_q();
        check(sda_oe == 1'b0, tag, sda_oe, 0);
    endtask

    task automatic send_byte(input logic [7:0] v, input bit exp_ack, input string tag);
        logic s;
        for (int i = 7; i >= 0; i--) bit_cycle(v[i], s);
        bit_cycle(1'b1, s);
        check((!s) == exp_ack, tag, !s, exp_ack);
    endtask

    task automatic recv_byte(input logic [7:0] exp, input bit mack, input string tag);
        logic s;
        logic [7:0] v;
        for (int i = 7; i >= 0; i--) begin
            bit_cycle(1'b1, s);
            v[i] = s;
        end
        bit_cycle(!mack, s);
        check(v == exp, tag, v, exp);
    endtask

    task automatic wr_byte(input logic [7:0] a, input logic [7:0] v, input string tag);
        if (in_win(a)) exp_wr.push_back({a, v});
        send_byte(v, 1'b1, tag);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) regs[i] = 8'h00;
        regs[8'h30] = 8'hEE;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(sda_oe == 1'b0 && rf_we == 1'b0, "R1 reset state released", sda_oe, 0);

        // R2 R4 R5: multi-byte write 08..0A
        do_start();
        send_byte(DW, 1'b1, "R2 device address ack");
        send_byte(8'h08, 1'b1, "R4 pointer ack");
        wr_byte(8'h08, 8'hA5, "R4 data ack");
        wr_byte(8'h09, 8'h3C, "R5 data ack");
        wr_byte(8'h0A, 8'h77, "R5 data ack");
        do_stop("R1 stop releases");

        // R9 R10: random read of 08 with sequential continuation
        do_start();
        send_byte(DW, 1'b1, "R9 device ack");
        send_byte(8'h08, 1'b1, "R9 pointer ack");
        do_start();
        send_byte(DR, 1'b1, "R9 read address ack");
        recv_byte(8'hA5, 1'b1, "R9 random read data");
        recv_byte(8'h3C, 1'b0, "R10 sequential read data");
        check(sda_oe == 1'b0, "R10 released after nack", sda_oe, 0);
        do_stop("R10 stop after nack");

        // R8: current-address read returns 0A
        do_start();
        send_byte(DR, 1'b1, "R8 read address ack");
        recv_byte(8'h77, 1'b0, "R8 current address read");
        do_stop("R8 stop");

        // R3: foreign address is ignored
        do_start();
        send_byte(8'hAA, 1'b0, "R3 no ack for foreign address");
        send_byte(8'h08, 1'b0, "R3 no ack after mismatch");
        send_byte(8'h99, 1'b0, "R3 no ack after mismatch");
        do_stop("R3 stop");

        // R6: write outside windows acked, no strobe
        do_start();
        send_byte(DW, 1'b1, "R6 device ack");
        send_byte(8'h20, 1'b1, "R6 pointer ack");
        wr_byte(8'h20, 8'h5A, "R6 data ack outside window");
        do_stop("R6 stop");

        // R7: read of unimplemented address returns 00
        do_start();
        send_byte(DW, 1'b1, "R7 device ack");
        send_byte(8'h30, 1'b1, "R7 pointer ack");
        do_start();
        send_byte(DR, 1'b1, "R7 read ack");
        recv_byte(8'h00, 1'b0, "R7 unimplemented reads zero");
        do_stop("R7 stop");

        // R5: pointer wrap FE,FF,00..09
        do_start();
        send_byte(DW, 1'b1, "R5 device ack");
        send_byte(8'hFE, 1'b1, "R5 pointer ack");
        for (int i = 0; i < 12; i++) begin
            logic [7:0] a;
            a = 8'(8'hFE + i);
            wr_byte(a, 8'(8'hC0 + i), "R5 wrap data ack");
        end
        do_stop("R5 stop");

        // R11: repeated start mid-byte discards partial byte
        do_start();
        send_byte(DW, 1'b1, "R11 device ack");
        send_byte(8'h10, 1'b1, "R11 pointer ack");
        begin
            logic s;
            for (int i = 0; i < 4; i++) bit_cycle(1'b0, s);
        end
        do_start();
        send_byte(DW, 1'b1, "R11 address matched after restart");
        send_byte(8'h11, 1'b1, "R11 pointer ack");
        wr_byte(8'h11, 8'h42, "R11 data ack");
        do_stop("R11 stop");

        // R12: short clock spike in a low phase is filtered
        do_start();
        send_byte(DW, 1'b1, "R12 device ack");
        send_byte(8'h45, 1'b1, "R12 pointer ack");
        sda_m = 1'b1;
        repeat (3) @(negedge clk);
        glitch = 1'b1;
        repeat (2) @(negedge clk);
        glitch = 1'b0;
        repeat (3) @(negedge clk);
        wr_byte(8'h45, 8'h81, "R12 data ack after spike");
        do_stop("R12 stop");

        // R12: read back through the bus
        do_start();
        send_byte(DW, 1'b1, "R12 device ack");
        send_byte(8'h45, 1'b1, "R12 pointer ack");
        do_start();
        send_byte(DR, 1'b1, "R12 read ack");
        recv_byte(8'h81, 1'b0, "R12 value after spike");
        do_stop("R12 stop");

        repeat (20) @(negedge clk);
        check(exp_wr.size() == 0, "R4 all expected writes seen", exp_wr.size(), 0);

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule